// File: doc/BRIEF.md
# Conditional Pause Controller

This block drives a hold line that freezes a running vector sequencer for as long as a pause condition is present. Four pause sources feed it, and software may enable any combination of them at once. The sources are a backplane trigger line, an external pause pin, a software pause bit, and an event source that watches a 16-bit event bus. The two off-board signals and the event bus arrive asynchronously, so each passes through a synchroniser before it reaches the hold decision.

The event source runs in one of two modes. In conditional mode it fires when the unmasked bits of the bus match a programmed pattern. In unconditional mode it ignores the bus and follows the external pause pin. For test-program checkout, a select bit can replace the live bus with a host-loaded emulation register. The hold output works only while the sequencer reports that it is running. A sticky cause vector records which enabled sources were active when the most recent pause began, and it stays set until software clears it.

Top module: `pause_ctrl`

## Requirements
- R1: After reset, `hold` is 0 and `cause` is 0.
- R2: The software pause (source bit 2 of `src_en`) raises `hold` on the first clock edge that samples `sw_pause` high while the source is enabled.
- R3: The trigger line (source bit 0) and the external pin (source bit 1) pass through two synchroniser stages, so `hold` rises on the third rising edge after the input goes high.
- R4: In conditional mode (`evt_cond` = 1) the event source (bit 3) is active when every bus bit whose `evt_mask` bit is 0 equals the matching `evt_pattern` bit. A mask bit of 1 excludes that bit from the compare.
- R5: In unconditional mode (`evt_cond` = 0) the event source follows the synchronised external pin and makes no bus compare.
- R6: With `emu_sel` = 1 the compare uses the emulation register in place of the bus. A pulse on `emu_load` writes `emu_data` into that register on the same edge.
- R7: `hold` is the OR of the enabled sources. A source whose enable bit is 0 has no effect.
- R8: While `run` is 0, `hold` is 0 one edge later, and no cause is recorded.
- R9: `hold` falls on the first edge at which no enabled source is active. It does not linger.
- R10: At the edge where `hold` rises, `cause` takes the mask of all enabled active sources, using bit order trig=0, ext=1, sw=2, evt=3. It then holds that value through the pause and after the release, and a source that joins mid-pause does not change it.
- R11: A `sticky_clr` pulse zeroes `cause`. If a new pause starts on the same edge, the new capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Sequencer running |
| src_en | input | 4 | Source enables: trig, ext, sw, evt |
| trig_line | input | 1 | Backplane trigger line, asynchronous |
| ext_pause | input | 1 | External pause pin, asynchronous |
| sw_pause | input | 1 | Software pause bit |
| evt_bus | input | 16 | External event bus, asynchronous |
| evt_pattern | input | 16 | Pause compare pattern |
| evt_mask | input | 16 | Compare mask, 1 = ignore bit |
| evt_cond | input | 1 | 1 = conditional, 0 = unconditional |
| emu_sel | input | 1 | Use emulation register instead of bus |
| emu_load | input | 1 | Load pulse for emulation register |
| emu_data | input | 16 | Emulation register load value |
| sticky_clr | input | 1 | Clear pulse for cause |
| hold | output | 1 | Freeze request to sequencer / paused status |
| cause | output | 4 | Sticky sources of the latest pause |

## Verification
The hardest case to reach is one where several sources with different synchroniser latencies become active on the same edge, because the sticky cause then has to capture all of them together. The stimulus sets up each case while `run` is low, waits for the synchronisers to settle, and only then raises `run`. Every enabled active source therefore reaches the hold decision at the same edge. Two further cases are driven directly with single-edge timing: a clear that coincides with a new pause, and a source that joins a pause already in progress.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_TRIG = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_SW   = 2;
  localparam int SRC_EVT  = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  // request gating: a source counts only when enabled and the sequencer runs
  function automatic src_vec_t gate_sources(input src_vec_t req,
                                            input src_vec_t en,
                                            input logic run);
    return run ? (req & en) : '0;
  endfunction
endpackage

// File: rtl/pause_sync.sv
module pause_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pause_evt_match.sv
module pause_evt_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_sync,
  input  logic         ext_sync,
  input  logic         emu_sel,
  input  logic         emu_load,
  input  logic [W-1:0] emu_data,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] mask,
  input  logic         cond_mode,
  output logic         evt_req
);
  // compare with don't-care bits: mask 1 removes a bit from the match
  function automatic logic masked_equal(input logic [W-1:0] val,
                                        input logic [W-1:0] pat,
                                        input logic [W-1:0] ign);
    return ((val ^ pat) & ~ign) == '0;
  endfunction

  logic [W-1:0] emu_q;
  logic [W-1:0] cmp_src;
  logic         evt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        emu_q <= '0;
    else if (emu_load) emu_q <= emu_data;
  end

  assign cmp_src = emu_sel ? emu_q : bus_sync;
  assign evt_hit = masked_equal(cmp_src, pattern, mask);
  assign evt_req = cond_mode ? evt_hit : ext_sync;

  assert_emu_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emu_load |=> (emu_q == $past(emu_data)));

  assert_mask_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode && (&mask)) |-> evt_req);
endmodule

// File: rtl/pause_hold_ctl.sv
module pause_hold_ctl
  import pause_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  src_vec_t req,
  input  src_vec_t en,
  input  logic     sticky_clr,
  output logic     hold,
  output src_vec_t cause
);
  src_vec_t gated;
  logic     hold_next;
  logic     hold_set;
  logic     hold_q;
  src_vec_t cause_q;

  assign gated     = gate_sources(req, en, run);
  assign hold_next = |gated;
  assign hold_set  = hold_next && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cause_q <= '0;
    else if (hold_set)   cause_q <= gated;
    else if (sticky_clr) cause_q <= '0;
  end

  assign hold  = hold_q;
  assign cause = cause_q;

  assert_idle_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hold_q);

  assert_rise_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> (cause_q != '0));

  assert_cause_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && !$past(sticky_clr)) |-> $stable(cause_q));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !hold_set) |=> (cause_q == '0));
endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
#(
  parameter int EVT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [3:0]       src_en,
  input  logic             trig_line,
  input  logic             ext_pause,
  input  logic             sw_pause,
  input  logic [EVT_W-1:0] evt_bus,
  input  logic [EVT_W-1:0] evt_pattern,
  input  logic [EVT_W-1:0] evt_mask,
  input  logic             evt_cond,
  input  logic             emu_sel,
  input  logic             emu_load,
  input  logic [EVT_W-1:0] emu_data,
  input  logic             sticky_clr,
  output logic             hold,
  output logic [3:0]       cause
);
  logic [1:0]       pin_sync;
  logic [EVT_W-1:0] bus_sync;
  logic             evt_req;
  src_vec_t         req;
  src_vec_t         cause_w;

  pause_sync #(.W(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_pause, trig_line}), .q(pin_sync));

  pause_sync #(.W(EVT_W), .STAGES(SYNC_STAGES)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(evt_bus), .q(bus_sync));

  pause_evt_match #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .bus_sync(bus_sync), .ext_sync(pin_sync[1]),
    .emu_sel(emu_sel), .emu_load(emu_load), .emu_data(emu_data),
    .pattern(evt_pattern), .mask(evt_mask), .cond_mode(evt_cond),
    .evt_req(evt_req));

  always_comb begin
    req           = '0;
    req[SRC_TRIG] = pin_sync[0];
    req[SRC_EXT]  = pin_sync[1];
    req[SRC_SW]   = sw_pause;
    req[SRC_EVT]  = evt_req;
  end

  pause_hold_ctl u_hold (
    .clk(clk), .rst_n(rst_n), .run(run), .req(req), .en(src_en),
    .sticky_clr(sticky_clr), .hold(hold), .cause(cause_w));

  assign cause = cause_w;

  assert_sw_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_en[SRC_SW] && sw_pause) |=> hold);
endmodule

// File: tb/pause_ctrl_bench.sv
module pause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [3:0]  src_en = '0;
  logic        trig_line = 1'b0, ext_pause = 1'b0, sw_pause = 1'b0;
  logic [15:0] evt_bus = '0, evt_pattern = '0, evt_mask = '0, emu_data = '0;
  logic        evt_cond = 1'b0, emu_sel = 1'b0, emu_load = 1'b0, sticky_clr = 1'b0;
  logic        hold;
  logic [3:0]  cause;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pause_ctrl u_pause_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en),
    .trig_line(trig_line), .ext_pause(ext_pause), .sw_pause(sw_pause),
    .evt_bus(evt_bus), .evt_pattern(evt_pattern), .evt_mask(evt_mask),
    .evt_cond(evt_cond), .emu_sel(emu_sel), .emu_load(emu_load),
    .emu_data(emu_data), .sticky_clr(sticky_clr), .hold(hold), .cause(cause));

  typedef struct packed {
    logic [3:0]  en;
    logic        sw, trig, ext;
    logic [15:0] bus, pat, msk;
    logic        cond, esel;
    logic [15:0] emu;
    logic        exp_hold;
    logic [3:0]  exp_cause;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'b0100,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,1'b1,4'b0100}, // R2
    '{4'b0000,1'b1,1'b1,1'b1,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,1'b0,4'b0000}, // R7
    '{4'b0001,1'b0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,1'b1,4'b0001}, // R3
    '{4'b1000,1'b0,1'b0,1'b0,16'hA5C3,16'hA5C3,16'h0000,1'b1,1'b0,16'h0000,1'b1,4'b1000}, // R4
    '{4'b1000,1'b0,1'b0,1'b0,16'hA5C3,16'hA5C2,16'h0000,1'b1,1'b0,16'h0000,1'b0,4'b0000}, // R4
    '{4'b1000,1'b0,1'b0,1'b0,16'hA5C3,16'hA5C2,16'h0001,1'b1,1'b0,16'h0000,1'b1,4'b1000}, // R4
    '{4'b1000,1'b0,1'b0,1'b1,16'h0000,16'hFFFF,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'b1000}, // R5
    '{4'b1000,1'b0,1'b0,1'b0,16'h1234,16'h1234,16'h0000,1'b0,1'b0,16'h0000,1'b0,4'b0000}, // R5
    '{4'b1000,1'b0,1'b0,1'b0,16'h0000,16'h1234,16'h0000,1'b1,1'b1,16'h1234,1'b1,4'b1000}, // R6
    '{4'b1000,1'b0,1'b0,1'b0,16'h1234,16'h1234,16'h0000,1'b1,1'b1,16'h1235,1'b0,4'b0000}, // R6
    '{4'b1111,1'b1,1'b1,1'b1,16'h00FF,16'h00FF,16'h0000,1'b1,1'b0,16'h0000,1'b1,4'b1111}, // R10
    '{4'b0110,1'b0,1'b1,1'b1,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,1'b1,4'b0010}  // R7
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    run = 1'b0; src_en = '0; sw_pause = 1'b0; trig_line = 1'b0; ext_pause = 1'b0;
    evt_bus = '0; evt_pattern = '0; evt_mask = '0; evt_cond = 1'b1; emu_sel = 1'b0;
    step(4);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    check("R1 hold", {31'd0, hold}, 32'd0);
    check("R1 cause", {28'd0, cause}, 32'd0);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      go_idle();
      src_en = TBL[i].en; sw_pause = TBL[i].sw; trig_line = TBL[i].trig;
      ext_pause = TBL[i].ext; evt_bus = TBL[i].bus; evt_pattern = TBL[i].pat;
      evt_mask = TBL[i].msk; evt_cond = TBL[i].cond; emu_sel = TBL[i].esel;
      emu_data = TBL[i].emu; emu_load = 1'b1;
      step(1);
      emu_load = 1'b0;
      step(3);
      check("R8 idle hold", {31'd0, hold}, 32'd0);
      check("R8 idle cause", {28'd0, cause}, 32'd0);
      run = 1'b1;
      step(1);
      check($sformatf("R7 row %0d hold", i), {31'd0, hold}, {31'd0, TBL[i].exp_hold});
      check($sformatf("R10 row %0d cause", i), {28'd0, cause}, {28'd0, TBL[i].exp_cause});
      step(2);
      check($sformatf("R7 row %0d hold kept", i), {31'd0, hold}, {31'd0, TBL[i].exp_hold});
    end

    // R3 synchroniser latency and R9 release through the synchroniser
    go_idle(); run = 1'b1; src_en = 4'b0010; step(1);
    ext_pause = 1'b1;
    step(1); check("R3 edge1", {31'd0, hold}, 32'd0);
    step(1); check("R3 edge2", {31'd0, hold}, 32'd0);
    step(1); check("R3 edge3", {31'd0, hold}, 32'd1);
    ext_pause = 1'b0;
    step(2); check("R9 still held", {31'd0, hold}, 32'd1);
    step(1); check("R9 released", {31'd0, hold}, 32'd0);
    check("R10 kept after release", {28'd0, cause}, 32'h2);

    // R2 one-edge software pause, R9 immediate release
    go_idle(); run = 1'b1; src_en = 4'b0100; step(1);
    sw_pause = 1'b1; step(1);
    check("R2 sw hold", {31'd0, hold}, 32'd1);
    sw_pause = 1'b0; step(1);
    check("R9 sw release", {31'd0, hold}, 32'd0);
    check("R10 sw cause kept", {28'd0, cause}, 32'h4);

    // R10 a source joining mid-pause does not change cause
    go_idle(); run = 1'b1; src_en = 4'b0101; step(1);
    sw_pause = 1'b1; step(1);
    check("R10 first cause", {28'd0, cause}, 32'h4);
    trig_line = 1'b1; step(4);
    check("R10 join no update", {28'd0, cause}, 32'h4);
    sw_pause = 1'b0; step(2);
    check("R7 trig keeps hold", {31'd0, hold}, 32'd1);
    trig_line = 1'b0; step(4);
    check("R9 all released", {31'd0, hold}, 32'd0);

    // R11 clear, then clear together with a new pause
    src_en = 4'b0100;
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    check("R11 cleared", {28'd0, cause}, 32'h0);
    sw_pause = 1'b1; sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    check("R11 capture wins", {28'd0, cause}, 32'h4);
    check("R11 hold", {31'd0, hold}, 32'd1);

    // R8 run dropped while held, then requests ignored while idle
    run = 1'b0; step(1);
    check("R8 drop run", {31'd0, hold}, 32'd0);
    check("R8 cause unchanged", {28'd0, cause}, 32'h4);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    step(3);
    check("R8 ignored hold", {31'd0, hold}, 32'd0);
    check("R8 ignored cause", {28'd0, cause}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule